// File: doc/BRIEF.md
# Memory Calibration Command Mailbox

This block is an AXI4-Lite register slave that acts as the command mailbox of a memory controller subsystem with several controller channels. Software writes a 32-bit command word. The block splits the word into a target type, an instance number, a command type and an opcode. For a recalibration command, it sends a one-cycle start pulse to the calibration engine of the selected channel. The slave then sets a response-ready flag when that engine finishes. Software polls this flag and clears it with a read-modify-write before it issues the next command. A separate read-only status register combines, across all enabled channels, whether any calibration passed, whether any failed and whether any is still running.

Each channel engine is a simple model. It stays busy for `CAL_CYCLES` clock cycles and then records a pass or a fail, taken from the `cal_pass` test input. Commands that are not recognised do not reach any engine. They complete at once with an error flag.

Three state machines drive the block:

- **Write channel**: `WR_IDLE` moves to `WR_RESP` when address and data are both valid (the *accept* transition). `WR_RESP` returns to `WR_IDLE` when `s_bready` is high (the *respond* transition).
- **Read channel**: `RD_IDLE` moves to `RD_DATA` on `s_arvalid`, which captures the read data. `RD_DATA` returns to `RD_IDLE` on `s_rready`.
- **Command sequencer**: `SQ_IDLE` moves to `SQ_LAUNCH` when it accepts a valid recalibration. `SQ_LAUNCH` always moves to `SQ_WAIT` and drives the start pulse. `SQ_WAIT` returns to `SQ_IDLE` when the engine signals done, and sets response-ready.

Each channel engine has its own machine. `EN_IDLE` moves to `EN_RUN` on start. `EN_RUN` returns to `EN_IDLE` when its counter reaches zero.

Top module: `cal_mailbox_axil`

## Requirements
- R1: After reset, the status (0x400), command (0x43C) and response (0x45C) registers all read 0, and `s_bvalid` and `s_rvalid` are low.
- R2: The command word holds the target type in bits [31:29], the instance number in [28:24], the command type in [23:16] and the opcode in [15:0]. Target type 1 selects channel 0 and target type 2 selects channel 1. The word 0x2005_000A recalibrates only channel 0, and 0x4005_000A recalibrates only channel 1.
- R3: While a recalibration runs, status bit 2 (busy) reads 1 and response bit 0 reads 0. Busy lasts exactly `CAL_CYCLES` cycles. After that, response bit 0 becomes 1 and bit 1 (error) reads 0.
- R4: Starting a recalibration clears that channel's pass and fail results. On completion, the channel records a pass if `cal_pass[ch]` is 1 and a fail otherwise.
- R5: A write to the response register with `wstrb[0]` set and data bit 0 at 0 clears the ready flag and leaves the error bit unchanged. A write with data bit 0 at 1, or with `wstrb[0]` low, leaves the ready flag set.
- R6: A write to the command register while a command is pending is dropped, with an OKAY response. A command is pending from its acceptance until software clears the ready flag. A dropped write changes neither the command register nor any channel.
- R7: A command is unrecognised if its target type is not 1 or 2, its instance is not 0, its command type is not 0x05, its opcode is not 0x000A, or its target channel is disabled. An unrecognised command sets the response register to 0x3 (ready and error) immediately and starts no calibration.
- R8: The status register reports, over enabled channels only, bit 0 for any pass, bit 1 for any fail and bit 2 for any busy. With no channel enabled, bits [2:0] read 0.
- R9: The command parameter words at 0x440 to 0x458 (word aligned) accept writes with an OKAY response, read 0, and affect nothing.
- R10: An access to any other address, including an unaligned one, returns SLVERR (2'b10), and its reads return 0. A write to the read-only status register returns OKAY and changes nothing.
- R11: `s_bvalid` and `s_rvalid` stay high until they are accepted, and `s_bresp`, `s_rdata` and `s_rresp` stay stable while they wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| ch_enable | input | NUM_CH | Per-channel enable; disabled channels are masked from status and refuse commands |
| cal_pass | input | NUM_CH | Per-channel calibration outcome used by the engine model |

## Verification
The hardest case to reach from the ports is a command write that arrives while another command is pending. The bench reaches it in two ways. First, it issues a second command word on the cycle right after the first write response, while the engine is still in `EN_RUN`. Second, it issues one after completion but before software clears the ready flag. In both cases the bench sets `cal_pass` so that the dropped command, had it run, would have changed the status register. It then reads back the command word and the status to prove that nothing moved.

// File: rtl/cal_mbox_pkg.sv
package cal_mbox_pkg;

    localparam int REG_W  = 32;
    localparam int STRB_W = REG_W / 8;

    // Register offsets; software polls these fixed locations.
    localparam logic [11:0] OFS_CAL_STAT = 12'h400;
    localparam logic [11:0] OFS_CMD      = 12'h43C;
    localparam logic [11:0] OFS_PARAM_LO = 12'h440;
    localparam logic [11:0] OFS_PARAM_HI = 12'h458;
    localparam logic [11:0] OFS_RESP     = 12'h45C;

    // Command decode constants
    localparam logic [7:0]  CTYPE_CAL = 8'h05;
    localparam logic [15:0] OPC_RECAL = 16'h000A;

    localparam logic [1:0] AXI_OKAY   = 2'b00;
    localparam logic [1:0] AXI_SLVERR = 2'b10;

    typedef struct packed {
        logic [2:0]  tgt;
        logic [4:0]  inst;
        logic [7:0]  ctype;
        logic [15:0] opc;
    } cmd_word_t;

    typedef enum logic { WR_IDLE, WR_RESP } wr_state_t;
    typedef enum logic { RD_IDLE, RD_DATA } rd_state_t;
    typedef enum logic [1:0] { SQ_IDLE, SQ_LAUNCH, SQ_WAIT } seq_state_t;
    typedef enum logic { EN_IDLE, EN_RUN } eng_state_t;

endpackage

// File: rtl/mbox_axil_port.sv
module mbox_axil_port
    import cal_mbox_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_awvalid,
    output logic             s_awready,
    input  logic             s_wvalid,
    output logic             s_wready,
    output logic [1:0]       s_bresp,
    output logic             s_bvalid,
    input  logic             s_bready,
    input  logic             s_arvalid,
    output logic             s_arready,
    output logic [REG_W-1:0] s_rdata,
    output logic [1:0]       s_rresp,
    output logic             s_rvalid,
    input  logic             s_rready,
    output logic             wr_fire,
    output logic             rd_fire,
    input  logic             wr_err,
    input  logic             rd_err,
    input  logic [REG_W-1:0] rd_data
);

    wr_state_t wst, wst_nx;
    rd_state_t rst_q, rst_nx;
    logic [1:0]       bresp_q;
    logic [1:0]       rresp_q;
    logic [REG_W-1:0] rdata_q;

    // state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wst   <= WR_IDLE;
            rst_q <= RD_IDLE;
        end else begin
            wst   <= wst_nx;
            rst_q <= rst_nx;
        end
    end

    // next state and handshake outputs
    always_comb begin
        wst_nx  = wst;
        wr_fire = 1'b0;
        unique case (wst)
            WR_IDLE: begin
                wr_fire = s_awvalid && s_wvalid;
                if (wr_fire) wst_nx = WR_RESP;
            end
            WR_RESP: if (s_bready) wst_nx = WR_IDLE;
            default: wst_nx = WR_IDLE;
        endcase
        rst_nx  = rst_q;
        rd_fire = 1'b0;
        unique case (rst_q)
            RD_IDLE: begin
                rd_fire = s_arvalid;
                if (rd_fire) rst_nx = RD_DATA;
            end
            RD_DATA: if (s_rready) rst_nx = RD_IDLE;
            default: rst_nx = RD_IDLE;
        endcase
    end

    assign s_awready = wr_fire;
    assign s_wready  = wr_fire;
    assign s_bvalid  = (wst == WR_RESP);
    assign s_arready = (rst_q == RD_IDLE);
    assign s_rvalid  = (rst_q == RD_DATA);
    assign s_bresp   = bresp_q;
    assign s_rresp   = rresp_q;
    assign s_rdata   = rdata_q;

    // response payload captured at acceptance, held until taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bresp_q <= AXI_OKAY;
            rresp_q <= AXI_OKAY;
            rdata_q <= '0;
        end else begin
            if (wr_fire) bresp_q <= wr_err ? AXI_SLVERR : AXI_OKAY;
            if (rd_fire) begin
                rresp_q <= rd_err ? AXI_SLVERR : AXI_OKAY;
                rdata_q <= rd_data;
            end
        end
    end

endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
    import cal_mbox_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              wr_fire,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [STRB_W-1:0] wr_strb,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [REG_W-1:0]  cmd_q,
    input  logic              resp_ready,
    input  logic              resp_err,
    input  logic [2:0]        stat_bits,
    output logic              cmd_wr,
    output logic [REG_W-1:0]  cmd_wdata,
    output logic              resp_clr,
    output logic              wr_err,
    output logic              rd_err,
    output logic [REG_W-1:0]  rd_data
);

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_CAL_STAT);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);
    localparam logic [ADDR_W-1:0] A_RESP = ADDR_W'(OFS_RESP);
    localparam logic [ADDR_W-1:0] A_PLO  = ADDR_W'(OFS_PARAM_LO);
    localparam logic [ADDR_W-1:0] A_PHI  = ADDR_W'(OFS_PARAM_HI);

    function automatic logic is_param(input logic [ADDR_W-1:0] a);
        return (a >= A_PLO) && (a <= A_PHI) && (a[1:0] == 2'b00);
    endfunction

    function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
        return (a == A_STAT) || (a == A_CMD) || (a == A_RESP) || is_param(a);
    endfunction

    logic [REG_W-1:0] lane_mask;

    // byte-lane merge of the command word
    always_comb begin
        for (int b = 0; b < STRB_W; b++) begin
            lane_mask[b*8 +: 8] = {8{wr_strb[b]}};
        end
        cmd_wdata = (cmd_q & ~lane_mask) | (wr_data & lane_mask);
    end

    assign cmd_wr   = wr_fire && (wr_addr == A_CMD);
    assign resp_clr = wr_fire && (wr_addr == A_RESP) && wr_strb[0] && !wr_data[0];
    assign wr_err   = !is_mapped(wr_addr);

    always_comb begin
        rd_data = '0;
        rd_err  = 1'b0;
        if (rd_addr == A_STAT)      rd_data = {{(REG_W-3){1'b0}}, stat_bits};
        else if (rd_addr == A_CMD)  rd_data = cmd_q;
        else if (rd_addr == A_RESP) rd_data = {{(REG_W-2){1'b0}}, resp_err, resp_ready};
        else if (!is_param(rd_addr)) rd_err = 1'b1;
    end

endmodule

// File: rtl/mbox_seq.sv
module mbox_seq
    import cal_mbox_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [REG_W-1:0]  cmd_wdata,
    input  logic              resp_clr,
    input  logic [NUM_CH-1:0] ch_enable,
    input  logic [NUM_CH-1:0] eng_done,
    output logic [NUM_CH-1:0] cal_start,
    output logic [REG_W-1:0]  cmd_q,
    output logic              resp_ready,
    output logic              resp_err
);

    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    seq_state_t state, state_nx;
    cmd_word_t  cmd_in;
    logic [CH_W-1:0] ch_sel, hit_sel;
    logic hit, hit_en, cmd_ok, pending, accept, finish;

    assign cmd_in = cmd_wdata;

    // target lookup: type value c+1 routes to channel c
    always_comb begin
        hit     = 1'b0;
        hit_en  = 1'b0;
        hit_sel = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (cmd_in.tgt == 3'(c + 1)) begin
                hit     = 1'b1;
                hit_en  = ch_enable[c];
                hit_sel = CH_W'(c);
            end
        end
        cmd_ok = hit && hit_en && (cmd_in.inst == 5'd0) &&
                 (cmd_in.ctype == CTYPE_CAL) && (cmd_in.opc == OPC_RECAL);
    end

    assign pending = (state != SQ_IDLE) || resp_ready;
    assign accept  = cmd_wr && !pending;
    assign finish  = (state == SQ_WAIT) && eng_done[ch_sel];

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx  = state;
        cal_start = '0;
        unique case (state)
            SQ_IDLE:   if (accept && cmd_ok) state_nx = SQ_LAUNCH;
            SQ_LAUNCH: begin
                cal_start = NUM_CH'(1) << ch_sel;
                state_nx  = SQ_WAIT;
            end
            SQ_WAIT:   if (eng_done[ch_sel]) state_nx = SQ_IDLE;
            default:   state_nx = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q      <= '0;
            ch_sel     <= '0;
            resp_ready <= 1'b0;
            resp_err   <= 1'b0;
        end else begin
            if (resp_clr) resp_ready <= 1'b0;
            if (accept) begin
                cmd_q <= cmd_wdata;
                if (cmd_ok) begin
                    ch_sel   <= hit_sel;
                    resp_err <= 1'b0;
                end else begin
                    resp_ready <= 1'b1;
                    resp_err   <= 1'b1;
                end
            end
            if (finish) resp_ready <= 1'b1;
        end
    end

endmodule

// File: rtl/cal_engine.sv
module cal_engine
    import cal_mbox_pkg::*;
#(
    parameter int CAL_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic pass_in,
    output logic busy,
    output logic ok,
    output logic bad,
    output logic done
);

    localparam int CNT_W = $clog2(CAL_CYCLES + 1);

    eng_state_t state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic last;

    assign last = (cnt == '0);
    assign busy = (state == EN_RUN);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= EN_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            EN_IDLE: if (start) state_nx = EN_RUN;
            EN_RUN:  if (last)  state_nx = EN_IDLE;
            default: state_nx = EN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            ok   <= 1'b0;
            bad  <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == EN_IDLE && start) begin
                cnt <= CNT_W'(CAL_CYCLES - 1);
                ok  <= 1'b0;
                bad <= 1'b0;
            end else if (state == EN_RUN) begin
                if (last) begin
                    ok   <= pass_in;
                    bad  <= !pass_in;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cal_mailbox_axil.sv
module cal_mailbox_axil
    import cal_mbox_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int NUM_CH     = 2,
    parameter int CAL_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [31:0]       s_wdata,
    input  logic [3:0]        s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [31:0]       s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    input  logic [NUM_CH-1:0] ch_enable,
    input  logic [NUM_CH-1:0] cal_pass
);

    logic wr_fire, rd_fire, wr_err, rd_err;
    logic [REG_W-1:0] rd_data, cmd_q, cmd_wdata;
    logic cmd_wr, resp_clr, resp_ready, resp_err;
    logic [NUM_CH-1:0] cal_start, eng_busy, eng_ok, eng_bad, eng_done;
    logic [2:0] stat_bits;

    mbox_axil_port u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_awvalid (s_awvalid),
        .s_awready (s_awready),
        .s_wvalid  (s_wvalid),
        .s_wready  (s_wready),
        .s_bresp   (s_bresp),
        .s_bvalid  (s_bvalid),
        .s_bready  (s_bready),
        .s_arvalid (s_arvalid),
        .s_arready (s_arready),
        .s_rdata   (s_rdata),
        .s_rresp   (s_rresp),
        .s_rvalid  (s_rvalid),
        .s_rready  (s_rready),
        .wr_fire   (wr_fire),
        .rd_fire   (rd_fire),
        .wr_err    (wr_err),
        .rd_err    (rd_err),
        .rd_data   (rd_data)
    );

    mbox_regs #(.ADDR_W(ADDR_W)) u_regs (
        .wr_fire    (wr_fire),
        .wr_addr    (s_awaddr),
        .wr_data    (s_wdata),
        .wr_strb    (s_wstrb),
        .rd_addr    (s_araddr),
        .cmd_q      (cmd_q),
        .resp_ready (resp_ready),
        .resp_err   (resp_err),
        .stat_bits  (stat_bits),
        .cmd_wr     (cmd_wr),
        .cmd_wdata  (cmd_wdata),
        .resp_clr   (resp_clr),
        .wr_err     (wr_err),
        .rd_err     (rd_err),
        .rd_data    (rd_data)
    );

    mbox_seq #(.NUM_CH(NUM_CH)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .cmd_wdata  (cmd_wdata),
        .resp_clr   (resp_clr),
        .ch_enable  (ch_enable),
        .eng_done   (eng_done),
        .cal_start  (cal_start),
        .cmd_q      (cmd_q),
        .resp_ready (resp_ready),
        .resp_err   (resp_err)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_eng
        cal_engine #(.CAL_CYCLES(CAL_CYCLES)) u_eng (
            .clk     (clk),
            .rst_n   (rst_n),
            .start   (cal_start[g]),
            .pass_in (cal_pass[g]),
            .busy    (eng_busy[g]),
            .ok      (eng_ok[g]),
            .bad     (eng_bad[g]),
            .done    (eng_done[g])
        );
    end

    // aggregated status over enabled channels: {busy, fail, pass}
    assign stat_bits = {|(eng_busy & ch_enable), |(eng_bad & ch_enable), |(eng_ok & ch_enable)};

endmodule

// File: rtl/mbox_chk.sv
module mbox_chk
    import cal_mbox_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int NUM_CH     = 2,
    parameter int CAL_CYCLES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] s_awaddr,
    input logic              s_awvalid,
    input logic              s_awready,
    input logic [31:0]       s_wdata,
    input logic [3:0]        s_wstrb,
    input logic [1:0]        s_bresp,
    input logic              s_bvalid,
    input logic              s_bready,
    input logic [31:0]       s_rdata,
    input logic [1:0]        s_rresp,
    input logic              s_rvalid,
    input logic              s_rready,
    input logic [NUM_CH-1:0] cal_start,
    input logic [NUM_CH-1:0] eng_busy,
    input logic [NUM_CH-1:0] eng_ok,
    input logic [NUM_CH-1:0] eng_bad,
    input logic              resp_ready
);

    logic clr_seen;
    assign clr_seen = s_awvalid && s_awready && (s_awaddr == ADDR_W'(OFS_RESP)) &&
                      s_wstrb[0] && !s_wdata[0];

    AST_BVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid && !s_bready |=> s_bvalid && $stable(s_bresp)); // R11
    AST_RVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata) && $stable(s_rresp)); // R11
    AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cal_start)); // R2
    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_start & eng_busy) == '0); // R6
    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        resp_ready && !clr_seen |=> resp_ready); // R5

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        int busy_len;
        always_ff @(posedge clk) begin
            if (!rst_n)           busy_len <= 0;
            else if (eng_busy[c]) busy_len <= busy_len + 1;
            else                  busy_len <= 0;
        end
        AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(eng_busy[c]) |-> busy_len == CAL_CYCLES); // R3
        AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(eng_busy[c]) |-> !eng_ok[c] && !eng_bad[c]); // R4
        AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(eng_busy[c]) |-> (eng_ok[c] != eng_bad[c])); // R4
    end

endmodule

bind cal_mailbox_axil mbox_chk #(
    .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CAL_CYCLES(CAL_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_awaddr   (s_awaddr),
    .s_awvalid  (s_awvalid),
    .s_awready  (s_awready),
    .s_wdata    (s_wdata),
    .s_wstrb    (s_wstrb),
    .s_bresp    (s_bresp),
    .s_bvalid   (s_bvalid),
    .s_bready   (s_bready),
    .s_rdata    (s_rdata),
    .s_rresp    (s_rresp),
    .s_rvalid   (s_rvalid),
    .s_rready   (s_rready),
    .cal_start  (cal_start),
    .eng_busy   (eng_busy),
    .eng_ok     (eng_ok),
    .eng_bad    (eng_bad),
    .resp_ready (resp_ready)
);

// File: tb/cal_mailbox_axil_test.sv
module cal_mailbox_axil_test;

    localparam int ADDR_W = 12;
    localparam int NCH    = 2;
    localparam int NCYC   = 8;

    localparam logic [11:0] A_STAT = 12'h400;
    localparam logic [11:0] A_CMD  = 12'h43C;
    localparam logic [11:0] A_RESP = 12'h45C;
    localparam logic [31:0] CMD_CH0 = 32'h2005_000A;
    localparam logic [31:0] CMD_CH1 = 32'h4005_000A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] awaddr = '0, araddr = '0;
    logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = 4'hF;
    logic awready, wready, bvalid, arready, rvalid;
    logic [1:0] bresp, rresp;
    logic [31:0] rdata;
    logic [NCH-1:0] ch_en = '1, pass = '1;

    int n_chk = 0, n_err = 0;
    logic [NCH-1:0] m_ok = '0, m_bad = '0;

    always #10 clk = ~clk;

    cal_mailbox_axil #(.ADDR_W(ADDR_W), .NUM_CH(NCH), .CAL_CYCLES(NCYC)) uut (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
        .ch_enable(ch_en), .cal_pass(pass)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic axi_wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s,
                          output logic [1:0] resp);
        @(negedge clk);
        awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1; bready = 1;
        #1;
        while (!awready) begin @(negedge clk); #1; end
        @(negedge clk);
        awvalid = 0; wvalid = 0;
        while (!bvalid) @(negedge clk);
        resp = bresp;
        @(negedge clk);
        bready = 0;
    endtask

    task automatic axi_rd(input logic [11:0] a, output logic [31:0] d, output logic [1:0] resp);
        @(negedge clk);
        araddr = a; arvalid = 1; rready = 1;
        #1;
        while (!arready) begin @(negedge clk); #1; end
        @(negedge clk);
        arvalid = 0;
        while (!rvalid) @(negedge clk);
        d = rdata; resp = rresp;
        @(negedge clk);
        rready = 0;
    endtask

    function automatic logic [31:0] exp_stat(input logic [NCH-1:0] en);
        return {29'b0, 1'b0, |(m_bad & en), |(m_ok & en)};
    endfunction

    task automatic wait_ready(input string req);
        logic [31:0] d; logic [1:0] r;
        int k = 0;
        d = '0;
        while (k < 40 && !d[0]) begin
            axi_rd(A_RESP, d, r);
            k++;
        end
        check(req, d, 32'h1);
    endtask

    task automatic clear_ready();
        logic [31:0] d; logic [1:0] r;
        axi_rd(A_RESP, d, r);
        axi_wr(A_RESP, d & 32'hFFFF_FFFE, 4'hF, r);
    endtask

    // runs a recalibration on channel ch with outcome p and checks busy/ready/outcome
    task automatic recal(input int ch, input logic p, input string req);
        logic [31:0] d; logic [1:0] r;
        pass[ch] = p;
        axi_wr(A_CMD, (ch == 0) ? CMD_CH0 : CMD_CH1, 4'hF, r);
        check({req, " bresp"}, {30'b0, r}, 32'h0);
        axi_rd(A_STAT, d, r);
        check({req, " R3 busy"}, {31'b0, d[2]}, 32'h1);
        axi_rd(A_RESP, d, r);
        check({req, " R3 not ready early"}, d, 32'h0);
        wait_ready({req, " R3 ready"});
        m_ok[ch] = p; m_bad[ch] = !p;
        axi_rd(A_STAT, d, r);
        check({req, " R4 status"}, d, exp_stat(ch_en));
        clear_ready();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] d, d2; logic [1:0] r;
        logic [31:0] bad_cmds [5];
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        check("R1 bvalid", {31'b0, bvalid}, 0);
        check("R1 rvalid", {31'b0, rvalid}, 0);
        axi_rd(A_STAT, d, r); check("R1 status", d, 0);
        axi_rd(A_CMD,  d, r); check("R1 command", d, 0);
        axi_rd(A_RESP, d, r); check("R1 response", d, 0);

        // R2 R3 R4: sweep channel and outcome
        for (int ch = 0; ch < NCH; ch++) begin
            for (int p = 0; p < 2; p++) begin
                recal(ch, p[0], "R2 R4 sweep");
                axi_rd(A_CMD, d, r);
                check("R2 command readback", d, (ch == 0) ? CMD_CH0 : CMD_CH1);
            end
        end
        // distinct outcomes per channel: ch0 pass, ch1 fail -> both bits
        recal(0, 1'b1, "R2 ch0");
        recal(1, 1'b0, "R2 ch1");
        axi_rd(A_STAT, d, r); check("R2 mixed status", d, 32'h3);

        // R5 clear semantics
        pass[0] = 1;
        axi_wr(A_CMD, CMD_CH0, 4'hF, r);
        wait_ready("R5 setup");
        m_ok[0] = 1; m_bad[0] = 0;
        axi_wr(A_RESP, 32'h1, 4'hF, r);
        axi_rd(A_RESP, d, r); check("R5 write one keeps ready", d, 32'h1);
        axi_wr(A_RESP, 32'h0, 4'hE, r);
        axi_rd(A_RESP, d, r); check("R5 lane0 off keeps ready", d, 32'h1);
        // R6 write while ready not yet cleared
        pass[1] = 1;
        axi_wr(A_CMD, CMD_CH1, 4'hF, r);
        check("R6 dropped write OKAY", {30'b0, r}, 0);
        axi_rd(A_CMD, d, r);  check("R6 command kept", d, CMD_CH0);
        axi_rd(A_STAT, d, r); check("R6 no launch", d, exp_stat(ch_en));
        axi_wr(A_RESP, 32'h0, 4'h1, r);
        axi_rd(A_RESP, d, r); check("R5 cleared", d, 32'h0);

        // R6 write while engine busy
        pass[0] = 0; pass[1] = 1;
        axi_wr(A_CMD, CMD_CH0, 4'hF, r);
        axi_wr(A_CMD, CMD_CH1, 4'hF, r);
        wait_ready("R6 busy drop ready");
        m_ok[0] = 0; m_bad[0] = 1;
        axi_rd(A_CMD, d, r);  check("R6 busy drop command", d, CMD_CH0);
        axi_rd(A_STAT, d, r); check("R6 busy drop ch1 untouched", d, exp_stat(ch_en));
        clear_ready();

        // R7 unrecognised commands
        bad_cmds[0] = 32'h0005_000A;
        bad_cmds[1] = 32'h6005_000A;
        bad_cmds[2] = 32'h2105_000A;
        bad_cmds[3] = 32'h2006_000A;
        bad_cmds[4] = 32'h2005_000B;
        foreach (bad_cmds[i]) begin
            axi_wr(A_CMD, bad_cmds[i], 4'hF, r);
            axi_rd(A_RESP, d, r); check("R7 immediate error", d, 32'h3);
            axi_rd(A_STAT, d, r); check("R7 no calibration", d, exp_stat(ch_en));
            clear_ready();
            axi_rd(A_RESP, d, r); check("R5 error kept after clear", d, 32'h2);
        end
        ch_en = 2'b01;
        axi_wr(A_CMD, CMD_CH1, 4'hF, r);
        axi_rd(A_RESP, d, r); check("R7 disabled channel", d, 32'h3);
        clear_ready();
        ch_en = 2'b11;
        recal(1, 1'b1, "R3 error cleared by valid");

        // R8 enable masking sweep: ch0 fail, ch1 pass
        for (int e = 0; e < 4; e++) begin
            ch_en = e[1:0];
            #1;
            axi_rd(A_STAT, d, r);
            check("R8 enable mask", d, exp_stat(e[1:0]));
        end
        ch_en = 2'b11;

        // R9 parameter words
        for (int a = 'h440; a <= 'h458; a += 4) begin
            axi_wr(12'(a), 32'hDEAD_BEEF, 4'hF, r);
            check("R9 param bresp", {30'b0, r}, 0);
            axi_rd(12'(a), d, r);
            check("R9 param read", {d[29:0], r}, 0);
        end
        axi_rd(A_CMD, d, r);  check("R9 command untouched", d, CMD_CH1);
        axi_rd(A_RESP, d, r); check("R9 response untouched", d, 0);

        // R10 unmapped and read-only
        axi_wr(12'h404, 32'hFFFF_FFFF, 4'hF, r); check("R10 write slverr", {30'b0, r}, 2);
        axi_rd(12'h404, d, r); check("R10 read slverr", {30'b0, r}, 2); check("R10 read zero", d, 0);
        axi_rd(12'h43D, d, r); check("R10 unaligned slverr", {30'b0, r}, 2);
        axi_rd(12'h460, d, r); check("R10 past end slverr", {30'b0, r}, 2);
        axi_wr(A_STAT, 32'h0, 4'hF, r); check("R10 status write OKAY", {30'b0, r}, 0);
        axi_rd(A_STAT, d, r); check("R10 status unchanged", d, exp_stat(ch_en));

        // R11 held responses
        @(negedge clk);
        araddr = A_STAT; arvalid = 1; rready = 0;
        @(negedge clk); arvalid = 0;
        d2 = rdata;
        repeat (3) begin
            @(negedge clk);
            check("R11 rvalid held", {31'b0, rvalid}, 1);
            check("R11 rdata stable", rdata, d2);
        end
        rready = 1; @(negedge clk); rready = 0;
        check("R11 rvalid dropped", {31'b0, rvalid}, 0);
        @(negedge clk);
        awaddr = 12'h404; wdata = 0; awvalid = 1; wvalid = 1; bready = 0;
        @(negedge clk); awvalid = 0; wvalid = 0;
        repeat (3) begin
            @(negedge clk);
            check("R11 bvalid held", {29'b0, bvalid, bresp}, 32'h6);
        end
        bready = 1; @(negedge clk); bready = 0;
        check("R11 bvalid dropped", {31'b0, bvalid}, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule